// File: doc/BRIEF.md
# Read Data Eye Right-Edge Search

This block finds the right edge of a read data eye by stepping a strobe delay setting upward from zero. At each setting an external capture path returns a word of captured read data, the expected pattern and a valid strobe. The step counts as passing only when the two words match bit for bit. The delay setting moves up by one after every reported step, and the recorded field is overwritten with the delay of every step as the sweep runs.

The sweep first crosses the failing region below the eye and then the passing region. On the first failing step after at least one passing step, the field is put back to the last passing delay and the block reports completion. If the sweep reaches the top delay while data still passes, the top delay is the result. If no step ever passes, the block raises an error instead of completion.

The field sits in the low bits of a result byte whose upper bits are reserved and always read as zero. Generating the data pattern and the physical delay line are outside this block.

Top module: `eye_edge_search`

## Requirements
- R1: `result_o` bits 7:6 are always zero, and bits 5:0 carry the recorded delay field.
- R2: A `start_i` pulse while `busy_o` is low makes the next cycle show `busy_o`=1, `dly_o`=0, field 0, `done_o`=0 and `err_o`=0. A `start_i` pulse while `busy_o` is high has no effect.
- R3: A step passes only when every bit of `cap_data_i` equals the same bit of `exp_data_i`. A single mismatching bit makes the step fail.
- R4: Each step reported with `res_valid_i`=1 while busy writes that step's delay into the field on the next cycle. If the step does not end the sweep, `dly_o` also advances by one.
- R5: The first failing step after any passing step ends the sweep. On the next cycle the field holds that step's delay minus one, `done_o`=1 and `busy_o`=0.
- R6: A passing step at delay 63 ends the sweep. On the next cycle the field holds 63, `done_o`=1 and `busy_o`=0.
- R7: A failing step at delay 63 with no earlier pass ends the sweep. On the next cycle `err_o`=1, `done_o`=0, `busy_o`=0 and the field holds 63. `done_o` and `err_o` are never high together.
- R8: `res_valid_i` has no effect while `busy_o` is low: `dly_o`, `result_o`, `done_o` and `err_o` stay unchanged.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `dly_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sweep; ignored while busy |
| res_valid_i | input | 1 | A capture result for the current delay is present |
| cap_data_i | input | 16 | Captured read data for this step |
| exp_data_i | input | 16 | Expected pattern for this step |
| dly_o | output | 6 | Strobe delay setting under test |
| result_o | output | 8 | Recorded delay in bits 5:0, bits 7:6 zero |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep completed with a found edge |
| err_o | output | 1 | Sweep ended with no passing step |

## Verification
Every result is due exactly one cycle after the rising edge that samples a start or a valid step: delay, field, done, error and busy are all registered once. The bench drives inputs on the falling edge. A behavioural model consumes the same inputs at the rising edge, and all outputs are compared against it on the following falling edge, so each comparison looks at the cycle in which that result is due. Pass windows are placed at the bottom, middle and top of the range and are also left empty. Mismatches of one bit and of all bits are both used, and start and valid pulses are sent while the block should ignore them.

// File: rtl/eye_edge_pkg.sv
// Shared types for the eye right-edge search.
// Assumes: used by all modules of the search; no logic here.
package eye_edge_pkg;

    // Sweep controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_DONE  = 2'd2,
        ST_ERR   = 2'd3
    } sweep_state_t;

endpackage

// File: rtl/eye_edge_cmp.sv
// Bitwise pattern compare: a step passes only when all bits match.
// Assumes: both words are valid in the same cycle; purely combinational.
module eye_edge_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cap_data_i,
    input  logic [DATA_W-1:0] exp_data_i,
    output logic              pass_o
);

    logic [DATA_W-1:0] bit_ok;

    // Per-bit equality lanes
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign bit_ok[g] = ~(cap_data_i[g] ^ exp_data_i[g]);
    end

    // Step passes when every lane agrees
    assign pass_o = &bit_ok;

endmodule

// File: rtl/eye_edge_ctrl.sv
// Sweep controller: steps the delay from zero, tracks whether any pass
// was seen, decides when the sweep ends, and issues field writes.
// Assumes: one valid result per delay setting; start ignored while sweeping.
module eye_edge_ctrl
    import eye_edge_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_valid_i,
    input  logic             step_pass_i,
    output logic [DLY_W-1:0] dly_o,
    output logic             found_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             clr_o,
    output logic             wr_o,
    output logic [DLY_W-1:0] wr_val_o
);

    localparam logic [DLY_W-1:0] DLY_MAX = '1;
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    sweep_state_t     st_q;
    logic [DLY_W-1:0] dly_q;
    logic             found_q;
    logic             at_top;

    assign at_top = (dly_q == DLY_MAX);

    // State, delay and pass-seen tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            dly_q   <= '0;
            found_q <= 1'b0;
        end else begin
            case (st_q)
                ST_SWEEP: begin
                    if (step_valid_i) begin
                        if (step_pass_i) begin
                            found_q <= 1'b1;
                            if (at_top) st_q  <= ST_DONE;
                            else        dly_q <= dly_q + DLY_ONE;
                        end else if (found_q) begin
                            st_q <= ST_DONE;
                        end else if (at_top) begin
                            st_q <= ST_ERR;
                        end else begin
                            dly_q <= dly_q + DLY_ONE;
                        end
                    end
                end
                default: begin
                    if (start_i) begin
                        st_q    <= ST_SWEEP;
                        dly_q   <= '0;
                        found_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Field write requests: every step writes, a closing fail rewinds by one
    always_comb begin
        clr_o    = start_i && (st_q != ST_SWEEP);
        wr_o     = (st_q == ST_SWEEP) && step_valid_i;
        wr_val_o = (!step_pass_i && found_q) ? (dly_q - DLY_ONE) : dly_q;
    end

    assign dly_o   = dly_q;
    assign found_o = found_q;
    assign busy_o  = (st_q == ST_SWEEP);
    assign done_o  = (st_q == ST_DONE);
    assign err_o   = (st_q == ST_ERR);

    AST_DLY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_valid_i && step_pass_i && !at_top) |=> (dly_o == $past(dly_o) + DLY_ONE)); // R4

    AST_TOP_PASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_valid_i && step_pass_i && at_top) |=> (done_o && !busy_o)); // R6

    AST_NO_PASS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_valid_i && !step_pass_i && !found_q && at_top) |=> (err_o && !done_o)); // R7

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R7

endmodule

// File: rtl/eye_edge_rec.sv
// Result field register: cleared on start, overwritten on each step write.
// Assumes: clear and write never both request in the same cycle.
module eye_edge_rec #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [DLY_W-1:0] wr_val_i,
    output logic [DLY_W-1:0] field_o
);

    logic [DLY_W-1:0] field_q;

    // Hold the recorded delay
    always_ff @(posedge clk) begin
        if (!rst_n)     field_q <= '0;
        else if (clr_i) field_q <= '0;
        else if (wr_i)  field_q <= wr_val_i;
    end

    assign field_o = field_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wr_i) |=> $stable(field_o)); // R8

endmodule

// File: rtl/eye_edge_search.sv
// Top of the read data eye right-edge search. Joins the compare, the
// sweep controller and the result register, and packs the field into a
// byte with zeroed reserved bits.
// Assumes: RES_W >= DLY_W; capture results arrive for the delay on dly_o.
module eye_edge_search #(
    parameter int DLY_W  = 6,
    parameter int DATA_W = 16,
    parameter int RES_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              res_valid_i,
    input  logic [DATA_W-1:0] cap_data_i,
    input  logic [DATA_W-1:0] exp_data_i,
    output logic [DLY_W-1:0]  dly_o,
    output logic [RES_W-1:0]  result_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int RSV_W = RES_W - DLY_W;
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    logic             step_pass;
    logic             found;
    logic             clr;
    logic             wr;
    logic [DLY_W-1:0] wr_val;
    logic [DLY_W-1:0] field;

    eye_edge_cmp #(.DATA_W(DATA_W)) cmp_i (
        .cap_data_i (cap_data_i),
        .exp_data_i (exp_data_i),
        .pass_o     (step_pass)
    );

    eye_edge_ctrl #(.DLY_W(DLY_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .step_valid_i (res_valid_i),
        .step_pass_i  (step_pass),
        .dly_o        (dly_o),
        .found_o      (found),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .clr_o        (clr),
        .wr_o         (wr),
        .wr_val_o     (wr_val)
    );

    eye_edge_rec #(.DLY_W(DLY_W)) rec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .wr_i     (wr),
        .wr_val_i (wr_val),
        .field_o  (field)
    );

    // Pack the field under zeroed reserved bits
    if (RSV_W > 0) begin : g_pad
        assign result_o = {{RSV_W{1'b0}}, field};
    end else begin : g_nopad
        assign result_o = field;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o >> DLY_W) == '0); // R1

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && dly_o == '0 && field == '0 && !done_o && !err_o)); // R2

    AST_STEP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && res_valid_i && step_pass) |=> (field == $past(dly_o))); // R4

    AST_REWIND_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && res_valid_i && !step_pass && found) |=>
            (done_o && !busy_o && field == $past(dly_o) - DLY_ONE)); // R5

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(dly_o) && $stable(result_o) && $stable(done_o) && $stable(err_o))); // R8

endmodule

// File: tb/eye_edge_search_tb.sv
module eye_edge_search_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DLY_W  = 6;
    localparam int DATA_W = 16;
    localparam int RES_W  = 8;
    localparam int TOP    = 63;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              res_valid_i = 1'b0;
    logic [DATA_W-1:0] cap_data_i = '0;
    logic [DATA_W-1:0] exp_data_i = '0;
    logic [DLY_W-1:0]  dly_o;
    logic [RES_W-1:0]  result_o;
    logic              busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // stimulus control
    int win_lo = -1, win_hi = -1;
    bit all_bits = 1'b0;
    bit resp_en = 1'b0;
    bit force_idle = 1'b0;
    bit cmp_en = 1'b0;

    // behavioural model state
    int  m_dly = 0, m_res = 0;
    bit  m_busy = 0, m_done = 0, m_err = 0, m_found = 0;

    eye_edge_search #(.DLY_W(DLY_W), .DATA_W(DATA_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .res_valid_i(res_valid_i),
        .cap_data_i(cap_data_i), .exp_data_i(exp_data_i), .dly_o(dly_o),
        .result_o(result_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model: consumes the inputs present at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_found = 0; m_dly = 0; m_res = 0;
        end else if (!m_busy) begin
            if (start_i) begin
                m_busy = 1; m_done = 0; m_err = 0; m_found = 0; m_dly = 0; m_res = 0;
            end
        end else if (res_valid_i) begin
            if (cap_data_i == exp_data_i) begin
                m_res = m_dly; m_found = 1;
                if (m_dly == TOP) begin m_done = 1; m_busy = 0; end
                else m_dly++;
            end else if (m_found) begin
                m_res = m_dly - 1; m_done = 1; m_busy = 0;
            end else begin
                m_res = m_dly;
                if (m_dly == TOP) begin m_err = 1; m_busy = 0; end
                else m_dly++;
            end
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(dly_o == DLY_W'(m_dly), "R4 dly_o", int'(dly_o), m_dly);
            check(result_o[5:0] == 6'(m_res), "R4 field", int'(result_o[5:0]), m_res);
            check(result_o[7:6] == 2'b00, "R1 reserved bits", int'(result_o[7:6]), 0);
            check(busy_o == m_busy, "R2 busy_o", int'(busy_o), int'(m_busy));
            check(done_o == m_done, "R5 done_o", int'(done_o), int'(m_done));
            check(err_o == m_err, "R7 err_o", int'(err_o), int'(m_err));
        end
    end

    // capture-result responder; R3 mismatches are one bit or all bits
    always @(negedge clk) begin
        logic [DATA_W-1:0] e;
        logic [DATA_W-1:0] mask;
        bit p;
        e = DATA_W'($urandom);
        mask = all_bits ? '1 : (DATA_W'(1) << ($urandom % DATA_W));
        p = !force_idle && (int'(dly_o) >= win_lo) && (int'(dly_o) <= win_hi) && (win_lo >= 0);
        res_valid_i <= (force_idle || (resp_en && busy_o)) && ($urandom % 4 != 0);
        exp_data_i  <= e;
        cap_data_i  <= p ? e : (e ^ mask);
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_sweep(input int lo, input int hi, input bit allb, input bit poke);
        int exp_res;
        bit exp_err;
        win_lo = lo; win_hi = hi; all_bits = allb; resp_en = 1'b1;
        pulse_start();
        check(busy_o && dly_o == '0 && result_o == '0, "R2 start clears", int'(busy_o), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;               // R2: must be ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        resp_en = 1'b0;
        exp_err = (lo < 0);
        exp_res = exp_err ? TOP : ((hi >= TOP) ? TOP : hi);
        check(result_o == RES_W'(exp_res), exp_err ? "R7 final field" : (hi >= TOP ? "R6 final field" : "R5 final field"),
              int'(result_o), exp_res);
        check(done_o == !exp_err, "R5 done at end", int'(done_o), int'(!exp_err));
        check(err_o == exp_err, "R7 err at end", int'(err_o), int'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !err_o && dly_o == '0 && result_o == '0, "R9 reset state", int'(result_o), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        run_sweep(5, 20, 1'b0, 1'b0);   // mid window, single-bit mismatch (R3)
        run_sweep(0, 10, 1'b1, 1'b1);   // pass at zero, restart poke
        run_sweep(40, 63, 1'b0, 1'b0);  // R6 passing at top
        run_sweep(63, 63, 1'b1, 1'b0);  // only top passes
        run_sweep(-1, -1, 1'b0, 1'b0);  // R7 no pass at all
        run_sweep(0, 63, 1'b0, 1'b1);   // all pass
        run_sweep(10, 10, 1'b0, 1'b0);  // single passing step, one-bit fails (R3)

        // R8: valid strobes while idle leave every output alone
        force_idle = 1'b1;
        repeat (12) @(negedge clk);
        force_idle = 1'b0;
        @(negedge clk);
        check(result_o == RES_W'(10) && done_o && !err_o, "R8 idle valid ignored", int'(result_o), 10);

        cmp_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule